// File: doc/BRIEF.md
# Three-Wire Serial Configuration Slave

This block receives write-only configuration for an audio converter over three slow lines: a mode line, a serial clock and a serial data line. All three are brought into the fast system clock domain through flip-flop synchronizers. The serial data is shifted in on each detected rising edge of the serial clock, least significant bit first, and assembled into whole bytes.

A byte sent while the mode line is low is an address byte. Its upper six bits are compared against the device address and its lower two bits choose a transfer type that remains in force for every following byte. A byte sent while the mode line is high is a payload byte. It is routed either to a status group (clock ratio, input format, DC filter enable) or to a sound group (volume, bass boost, treble, de-emphasis, mute, tone mode, power control), with the top bits of the byte choosing the register inside the sound group. The register contents drive the converter directly as static outputs.

Top module: `tw_cfg_slave`

## Requirements
- R1: After reset every output register field is zero and the interface is deselected, so payload bytes sent before any address byte change no output.
- R2: A byte received with the mode line low is an address byte; bits are taken least significant first, and an address whose bits 7:2 equal 000101 selects the interface.
- R3: An address byte with any other value in bits 7:2 deselects the interface, and payload bytes then change no output until a matching address byte arrives.
- R4: Address bits 1:0 give the transfer type: 00 selects the sound group, 10 selects the status group, and 01 or 11 make every following payload byte write nothing.
- R5: The selected device and transfer type stay in force across any number of consecutive payload bytes.
- R6: A register is written only once the eighth bit of a byte has been shifted in; any change of the mode line discards a partly received byte.
- R7: In the status group a payload byte with bit 7 = 0 loads clock ratio from bits 5:4, input format from bits 3:1 and DC filter enable from bit 0; a byte with bit 7 = 1 changes nothing.
- R8: In the sound group a payload byte with bits 7:6 = 00 loads the 6-bit volume from bits 5:0.
- R9: In the sound group bits 7:6 = 01 load bass boost from bits 5:2 and treble from bits 1:0.
- R10: In the sound group bits 7:6 = 10 load de-emphasis from bits 4:3, mute from bit 2 and tone mode from bits 1:0.
- R11: In the sound group bits 7:6 = 11 load power control from bits 1:0.
- R12: The data line is sampled at the rising edge of the serial clock; a change of the data line while the serial clock is high has no effect on the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_mode_i | input | 1 | Mode line: low for address bytes, high for payload bytes |
| ser_clk_i | input | 1 | Serial clock, idles high |
| ser_dat_i | input | 1 | Serial data, least significant bit first |
| clk_ratio_o | output | 2 | Status: system clock ratio select |
| in_fmt_o | output | 3 | Status: serial audio input format select |
| dc_en_o | output | 1 | Status: DC removal filter enable |
| volume_o | output | 6 | Sound: attenuation code |
| bass_o | output | 4 | Sound: bass boost code |
| treble_o | output | 2 | Sound: treble code |
| deemph_o | output | 2 | Sound: de-emphasis select |
| mute_o | output | 1 | Sound: mute enable |
| tone_mode_o | output | 2 | Sound: tone filter set select |
| power_o | output | 2 | Sound: converter power enables |

## Verification
The selection state (matched address and transfer type) is never visible directly, so a wrong value there shows up only at the next payload byte, as an output field that changes when it should hold or holds when it should change, about five system clocks after that byte's eighth rising serial-clock edge. A miscounted bit counter shows as a shifted or misrouted field on the very next byte and on every byte after it until the mode line toggles. The bench therefore compares every output field after each byte against a bench model, mixing random address and payload bytes with directed cases for wrong addresses, unused types, ignored status bytes, aborted bytes and data changing while the serial clock is high.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;

   localparam int unsigned BYTE_BITS = 8;
   localparam int unsigned ADDR_BITS = 6;

   typedef enum logic [1:0] {
      XFER_SOUND  = 2'b00,
      XFER_RSVD_A = 2'b01,
      XFER_STATUS = 2'b10,
      XFER_RSVD_B = 2'b11
   } xfer_t;

   typedef enum logic [1:0] {
      SND_VOLUME = 2'b00,
      SND_TONE   = 2'b01,
      SND_MISC   = 2'b10,
      SND_POWER  = 2'b11
   } snd_sel_t;

   typedef struct packed {
      logic [1:0] clk_ratio;
      logic [2:0] in_fmt;
      logic       dc_en;
   } status_t;

   typedef struct packed {
      logic [5:0] volume;
      logic [3:0] bass;
      logic [1:0] treble;
      logic [1:0] deemph;
      logic       mute;
      logic [1:0] tone_mode;
      logic [1:0] power;
   } sound_t;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int unsigned      STAGES  = 2,
   parameter int unsigned      WIDTH   = 3,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   initial begin
      if (STAGES < 2) $fatal(1, "tw_sync: STAGES must be at least 2");
      if (WIDTH < 1)  $fatal(1, "tw_sync: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
         else        chain <= {chain[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain[STAGES-1];
   end

endmodule

// File: rtl/tw_byte_rx.sv
module tw_byte_rx #(
   parameter int unsigned BITS      = 8,
   parameter bit          LSB_FIRST = 1'b1,
   parameter bit          CLK_IDLE  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sclk_s,
   input  logic            mode_s,
   input  logic            dat_s,
   output logic            byte_vld_o,
   output logic [BITS-1:0] byte_o,
   output logic            byte_mode_o
);

   localparam int unsigned      CW   = (BITS > 1) ? $clog2(BITS) : 1;
   localparam logic [CW-1:0]    LAST = CW'(BITS - 1);

   initial begin
      if (BITS < 2) $fatal(1, "tw_byte_rx: BITS must be at least 2");
   end

   logic            sclk_q;
   logic            mode_q;
   logic [CW-1:0]   cnt;
   logic [BITS-1:0] shreg;
   logic [BITS-1:0] shifted;
   logic            rise;
   logic            mode_chg;

   assign rise     = sclk_s & ~sclk_q;
   assign mode_chg = mode_s ^ mode_q;

   if (LSB_FIRST) begin : g_lsb
      assign shifted = {dat_s, shreg[BITS-1:1]};
   end else begin : g_msb
      assign shifted = {shreg[BITS-2:0], dat_s};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q      <= CLK_IDLE;
         mode_q      <= 1'b0;
         cnt         <= '0;
         shreg       <= '0;
         byte_vld_o  <= 1'b0;
         byte_o      <= '0;
         byte_mode_o <= 1'b0;
      end else begin
         sclk_q     <= sclk_s;
         mode_q     <= mode_s;
         byte_vld_o <= 1'b0;
         if (mode_chg) begin
            cnt <= '0;
         end else if (rise) begin
            shreg <= shifted;
            if (cnt == LAST) begin
               cnt         <= '0;
               byte_vld_o  <= 1'b1;
               byte_o      <= shifted;
               byte_mode_o <= mode_s;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R6: a mode change aborts any byte in progress
   assert_mode_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |=> !byte_vld_o);

   // R6: whole bytes need many serial edges, so completions never touch
   assert_byte_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |=> !byte_vld_o);

endmodule

// File: rtl/tw_regfile.sv
module tw_regfile
   import tw_cfg_pkg::*;
#(
   parameter logic [ADDR_BITS-1:0] DEV_ADDR = 6'b000101
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 byte_vld_i,
   input  logic [BYTE_BITS-1:0] byte_i,
   input  logic                 byte_mode_i,
   output status_t              status_o,
   output sound_t               sound_o
);

   logic     selected;
   xfer_t    xfer;
   status_t  st_q;
   sound_t   snd_q;
   snd_sel_t snd_sel;

   assign snd_sel = snd_sel_t'(byte_i[7:6]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         selected <= 1'b0;
         xfer     <= XFER_SOUND;
         st_q     <= '0;
         snd_q    <= '0;
      end else if (byte_vld_i) begin
         if (!byte_mode_i) begin
            selected <= (byte_i[BYTE_BITS-1:2] == DEV_ADDR);
            xfer     <= xfer_t'(byte_i[1:0]);
         end else if (selected) begin
            unique case (xfer)
               XFER_STATUS: begin
                  if (!byte_i[7]) begin
                     st_q.clk_ratio <= byte_i[5:4];
                     st_q.in_fmt    <= byte_i[3:1];
                     st_q.dc_en     <= byte_i[0];
                  end
               end
               XFER_SOUND: begin
                  unique case (snd_sel)
                     SND_VOLUME: snd_q.volume <= byte_i[5:0];
                     SND_TONE: begin
                        snd_q.bass   <= byte_i[5:2];
                        snd_q.treble <= byte_i[1:0];
                     end
                     SND_MISC: begin
                        snd_q.deemph    <= byte_i[4:3];
                        snd_q.mute      <= byte_i[2];
                        snd_q.tone_mode <= byte_i[1:0];
                     end
                     SND_POWER: snd_q.power <= byte_i[1:0];
                  endcase
               end
               default: ;
            endcase
         end
      end
   end

   assign status_o = st_q;
   assign sound_o  = snd_q;

   // R6: registers move only on a completed byte
   assert_write_on_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld_i |=> ($stable(st_q) && $stable(snd_q)));

   // R1, R3: a deselected interface writes nothing
   assert_deselect_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld_i && byte_mode_i && !selected) |=> ($stable(st_q) && $stable(snd_q)));

   // R4: unused transfer types write nothing
   assert_rsvd_type_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld_i && byte_mode_i && (xfer == XFER_RSVD_A || xfer == XFER_RSVD_B))
      |=> ($stable(st_q) && $stable(snd_q)));

   // R7: status bytes with the top bit set are ignored
   assert_status_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld_i && byte_mode_i && xfer == XFER_STATUS && byte_i[7])
      |=> ($stable(st_q) && $stable(snd_q)));

   // R2: address bytes never touch the configuration
   assert_addr_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld_i && !byte_mode_i) |=> ($stable(st_q) && $stable(snd_q)));

endmodule

// File: rtl/tw_cfg_slave.sv
module tw_cfg_slave
   import tw_cfg_pkg::*;
#(
   parameter int unsigned          SYNC_STAGES = 2,
   parameter bit                   LSB_FIRST   = 1'b1,
   parameter logic [ADDR_BITS-1:0] DEV_ADDR    = 6'b000101
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ser_mode_i,
   input  logic       ser_clk_i,
   input  logic       ser_dat_i,
   output logic [1:0] clk_ratio_o,
   output logic [2:0] in_fmt_o,
   output logic       dc_en_o,
   output logic [5:0] volume_o,
   output logic [3:0] bass_o,
   output logic [1:0] treble_o,
   output logic [1:0] deemph_o,
   output logic       mute_o,
   output logic [1:0] tone_mode_o,
   output logic [1:0] power_o
);

   localparam int unsigned LINES    = 3;
   localparam logic [LINES-1:0] LINE_RST = 3'b100;

   logic [LINES-1:0]     lines_s;
   logic                 byte_vld;
   logic [BYTE_BITS-1:0] byte_val;
   logic                 byte_mode;
   status_t              st;
   sound_t               snd;

   tw_sync #(
      .STAGES  (SYNC_STAGES),
      .WIDTH   (LINES),
      .RST_VAL (LINE_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({ser_clk_i, ser_mode_i, ser_dat_i}),
      .q_o   (lines_s)
   );

   tw_byte_rx #(
      .BITS      (BYTE_BITS),
      .LSB_FIRST (LSB_FIRST),
      .CLK_IDLE  (LINE_RST[2])
   ) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk_s      (lines_s[2]),
      .mode_s      (lines_s[1]),
      .dat_s       (lines_s[0]),
      .byte_vld_o  (byte_vld),
      .byte_o      (byte_val),
      .byte_mode_o (byte_mode)
   );

   tw_regfile #(
      .DEV_ADDR (DEV_ADDR)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .byte_vld_i  (byte_vld),
      .byte_i      (byte_val),
      .byte_mode_i (byte_mode),
      .status_o    (st),
      .sound_o     (snd)
   );

   assign clk_ratio_o = st.clk_ratio;
   assign in_fmt_o    = st.in_fmt;
   assign dc_en_o     = st.dc_en;
   assign volume_o    = snd.volume;
   assign bass_o      = snd.bass;
   assign treble_o    = snd.treble;
   assign deemph_o    = snd.deemph;
   assign mute_o      = snd.mute;
   assign tone_mode_o = snd.tone_mode;
   assign power_o     = snd.power;

endmodule

// File: tb/tb_tw_cfg_slave.sv
module tb_tw_cfg_slave;

   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_mode = 1'b0;
   logic ser_clk = 1'b1;
   logic ser_dat = 1'b0;
   logic [1:0] clk_ratio;
   logic [2:0] in_fmt;
   logic       dc_en;
   logic [5:0] volume;
   logic [3:0] bass;
   logic [1:0] treble;
   logic [1:0] deemph;
   logic       mute;
   logic [1:0] tone_mode;
   logic [1:0] power;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // bench model of the configuration
   logic [24:0] exp_v = '0;
   bit          m_sel = 1'b0;
   logic [1:0]  m_type = 2'b00;

   always #5 clk = ~clk;

   tw_cfg_slave dut (
      .clk (clk), .rst_n (rst_n),
      .ser_mode_i (ser_mode), .ser_clk_i (ser_clk), .ser_dat_i (ser_dat),
      .clk_ratio_o (clk_ratio), .in_fmt_o (in_fmt), .dc_en_o (dc_en),
      .volume_o (volume), .bass_o (bass), .treble_o (treble),
      .deemph_o (deemph), .mute_o (mute), .tone_mode_o (tone_mode),
      .power_o (power)
   );

   function automatic logic [24:0] observed();
      return {clk_ratio, in_fmt, dc_en, volume, bass, treble, deemph, mute, tone_mode, power};
   endfunction

   // field positions within exp_v: [24:23] ratio [22:20] fmt [19] dc [18:13] vol
   // [12:9] bass [8:7] treble [6:5] deemph [4] mute [3:2] tone mode [1:0] power
   task automatic model_byte(input bit m, input logic [7:0] b, output string tag);
      if (!m) begin
         m_sel  = (b[7:2] == 6'b000101);
         m_type = b[1:0];
         tag = m_sel ? "R2" : "R3";
      end else if (!m_sel) begin
         tag = "R3";
      end else if (m_type == 2'b10) begin
         if (!b[7]) begin
            exp_v[24:23] = b[5:4];
            exp_v[22:20] = b[3:1];
            exp_v[19]    = b[0];
         end
         tag = "R7";
      end else if (m_type == 2'b00) begin
         case (b[7:6])
            2'b00: begin exp_v[18:13] = b[5:0]; tag = "R8"; end
            2'b01: begin exp_v[12:9] = b[5:2]; exp_v[8:7] = b[1:0]; tag = "R9"; end
            2'b10: begin exp_v[6:5] = b[4:3]; exp_v[4] = b[2]; exp_v[3:2] = b[1:0]; tag = "R10"; end
            default: begin exp_v[1:0] = b[1:0]; tag = "R11"; end
         endcase
      end else begin
         tag = "R4";
      end
   endtask

   task automatic chk(input string tag);
      logic [24:0] act;
      act = observed();
      checks++;
      if (act !== exp_v) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp_v);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_mode(input bit m);
      if (ser_mode != m) begin
         ser_mode = m;
         cyc(HALF);
      end
   endtask

   task automatic send_bit(input bit v, input bit wiggle);
      ser_clk = 1'b0;
      ser_dat = v;
      cyc(HALF);
      ser_clk = 1'b1;
      cyc(HALF / 2);
      if (wiggle) ser_dat = ~v;
      cyc(HALF / 2);
   endtask

   task automatic send_byte(input bit m, input logic [7:0] b, input bit wiggle, input string tag_in);
      string tag;
      set_mode(m);
      for (int i = 0; i < 8; i++) send_bit(b[i], wiggle);
      cyc(12);
      model_byte(m, b, tag);
      chk((tag_in.len() > 0) ? tag_in : tag);
   endtask

   initial begin
      void'($urandom(32'd4177));
      cyc(4);
      rst_n = 1'b1;
      cyc(6);
      chk("R1");                                   // reset state
      send_byte(1'b1, 8'h2A, 1'b0, "R1");          // payload before any address
      send_byte(1'b0, 8'h14, 1'b0, "R2");          // matching address, sound group
      send_byte(1'b1, 8'h2A, 1'b0, "R8");
      send_byte(1'b1, 8'h6D, 1'b0, "R9");          // selection persists
      send_byte(1'b1, 8'h9E, 1'b0, "R10");
      send_byte(1'b1, 8'hC2, 1'b0, "R11");
      send_byte(1'b1, 8'h3F, 1'b0, "R5");
      send_byte(1'b0, 8'h16, 1'b0, "R4");          // status group
      send_byte(1'b1, 8'h2B, 1'b0, "R7");
      send_byte(1'b1, 8'hFF, 1'b0, "R7");          // bit 7 set: ignored
      send_byte(1'b0, 8'h15, 1'b0, "R4");          // unused type 01
      send_byte(1'b1, 8'h00, 1'b0, "R4");
      send_byte(1'b0, 8'h17, 1'b0, "R4");          // unused type 11
      send_byte(1'b1, 8'h11, 1'b0, "R4");
      send_byte(1'b0, 8'h1C, 1'b0, "R3");          // wrong address
      send_byte(1'b1, 8'h05, 1'b0, "R3");
      send_byte(1'b1, 8'hC3, 1'b0, "R3");
      send_byte(1'b0, 8'h14, 1'b0, "R2");
      // R6: partial byte then mode toggle discards it
      set_mode(1'b1);
      for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
      cyc(12);
      chk("R6");
      set_mode(1'b0);
      set_mode(1'b1);
      send_byte(1'b1, 8'h07, 1'b0, "R6");
      // R12: data flips while serial clock is high
      send_byte(1'b1, 8'h19, 1'b1, "R12");
      send_byte(1'b1, 8'h5A, 1'b1, "R12");
      // random traffic
      for (int k = 0; k < 220; k++) begin
         logic [7:0] b;
         bit m;
         if ($urandom % 4 == 0) begin
            m = 1'b0;
            b[7:2] = ($urandom % 3 == 0) ? 6'($urandom) : 6'b000101;
            b[1:0] = 2'($urandom);
         end else begin
            m = 1'b1;
            b = 8'($urandom);
         end
         send_byte(m, b, 1'($urandom), "");
      end
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule